// File: doc/BRIEF.md
# Serial ADC Single-Sample Readout Controller

This block sits on the host side of a 12-bit serial analog-to-digital converter and reads one sample for each start request. A start pulse received while the block is idle pulls the active-low chip select low. The block then produces a serial clock by dividing the system clock, and samples the converter's data line on every rising serial-clock edge. The first two rising edges fall inside the converter's acquisition interval and are discarded. The third rising edge must see a forced-low null bit. The next twelve rising edges carry the result, most significant bit first.

In compare mode the block keeps clocking through the converter's least-significant-bit-first repeat, which carries B1 up to B11 (B0 is not sent again). It checks each repeated bit against the word it captured first. At the end it drives the serial clock low, raises chip select, holds it high for one half serial period, and then presents the straight-binary word with a one-cycle valid pulse. An error flag rises with valid if the null bit was high or if the repeat disagreed with the first copy.

States: IDLE (chip select high, waiting for start) → LEAD (chip select low, clock low, one half period) → HIGH ⇄ LOW (serial clock phases; the LOW→HIGH and LEAD→HIGH transitions are the sampling points) → FIN (clock low, chip select high, one half period) → IDLE, and valid pulses on that last transition. HIGH goes to FIN in place of LOW once the final rising edge of the selected mode has been counted.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: After synchronous reset, cs_n is 1, dclk is 0, and busy, valid and error are 0.
- R2: A start pulse seen while idle drops cs_n and raises busy. A start pulse seen while busy is ignored, so each conversion produces exactly one falling edge of cs_n.
- R3: Each serial-clock level, including the low lead-in between cs_n falling and the first rising dclk edge, lasts exactly HALF_DIV system cycles. dclk is never high while cs_n is high.
- R4: The first two rising dclk edges are not used. The third samples the null bit, and a 1 there sets error for that conversion.
- R5: Rising edges 4 to 15 sample B11 down to B0. data_out is the 12-bit straight-binary code, so 0x000 means zero, 0x800 midscale and 0xFFF full scale.
- R6: With compare mode off, exactly 15 rising dclk edges occur per conversion. Bits on the data line after B0 do not affect error.
- R7: With compare mode on, exactly 26 rising edges occur, and edges 16 to 26 carry B1 to B11. Any difference from the first copy sets error. The mode is sampled at start, and later changes of cmp_mode do not affect the conversion in progress.
- R8: After the last rising edge, dclk falls and cs_n rises. cs_n stays high for at least HALF_DIV cycles before valid pulses for exactly one cycle. During that cycle busy is 0, and data_out and error hold until the next valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one sample |
| cmp_mode | input | 1 | 1 = also read and check the LSB-first repeat |
| busy | output | 1 | Conversion in progress |
| data_out | output | DATA_W | Captured straight-binary result |
| valid | output | 1 | One-cycle result strobe |
| error | output | 1 | Null bit high or repeat mismatch |
| cs_n | output | 1 | Converter chip select, active low |
| dclk | output | 1 | Serial clock to converter |
| din | input | 1 | Serial data from converter |

## Verification
A rise counter that is off by one moves the whole data window by one edge. It shows at the first valid as a word shifted by one bit, a false null error, or a rising-edge count of 14, 16, 25 or 27. A fault in the phase divider shows within the first half period as a lead-in or high time other than HALF_DIV. A stuck compare path shows only in compare mode, as an error that is missing when a single repeat bit has been flipped. The sweep therefore flips each of the eleven repeat positions in turn.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_FIN
    } rd_state_t;
endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int PW = $clog2(HALF_DIV);
            logic [PW-1:0] ph_q;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    ph_q <= '0;
                end else if (ph_q == PW'(HALF_DIV - 1)) begin
                    ph_q <= '0;
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end

            assign tick = run && (ph_q == PW'(HALF_DIV - 1));

            // R3: phase counter never leaves its range
            a_r3_phase_in_range: assert property (@(posedge clk) disable iff (rst)
                ph_q <= PW'(HALF_DIV - 1));
            // R3: phase restarts while the clock generator is stopped
            a_r3_phase_idle_zero: assert property (@(posedge clk) disable iff (rst)
                !run |=> ph_q == '0);
        end
    endgenerate
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
    parameter int DATA_W = 12,
    parameter int CW     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              smpl,
    input  logic [CW-1:0]     idx,
    input  logic              din,
    output logic [DATA_W-1:0] word,
    output logic              fault
);
    localparam int NULL_RISE  = 3;
    localparam int FIRST_DATA = NULL_RISE + 1;
    localparam int LAST_DATA  = NULL_RISE + DATA_W;
    localparam int IW         = $clog2(DATA_W);

    logic [CW-1:0] rep_pos;
    logic          in_null;
    logic          in_data;
    logic          in_rep;

    assign rep_pos = idx - CW'(LAST_DATA);
    assign in_null = (idx == CW'(NULL_RISE));
    assign in_data = (idx >= CW'(FIRST_DATA)) && (idx <= CW'(LAST_DATA));
    assign in_rep  = (idx > CW'(LAST_DATA));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word  <= '0;
            fault <= 1'b0;
        end else if (smpl) begin
            if (in_null && din) begin
                fault <= 1'b1;
            end
            if (in_data) begin
                word <= {word[DATA_W-2:0], din};
            end
            if (in_rep && (din != word[rep_pos[IW-1:0]])) begin
                fault <= 1'b1;
            end
        end
    end

    // R4: a clear always leaves the fault flag low on the next cycle
    a_r4_clear_drops_fault: assert property (@(posedge clk) disable iff (rst)
        clear |=> !fault);
    // R5: word changes only on a sample or a clear
    a_r5_word_only_on_sample: assert property (@(posedge clk) disable iff (rst)
        !smpl && !clear |=> $stable(word));
endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cmp_mode,
    output logic              busy,
    output logic [DATA_W-1:0] data_out,
    output logic              valid,
    output logic              error,
    output logic              cs_n,
    output logic              dclk,
    input  logic              din
);
    localparam int NULL_RISE = 3;
    localparam int LAST_DATA = NULL_RISE + DATA_W;
    localparam int LAST_REP  = LAST_DATA + DATA_W - 1;
    localparam int CW        = $clog2(LAST_REP + 1);

    rd_state_t         state_q;
    rd_state_t         state_d;
    logic [CW-1:0]     rise_q;
    logic [CW-1:0]     last_rise;
    logic              cmp_q;
    logic              tick;
    logic              run;
    logic              smpl;
    logic              clear;
    logic [DATA_W-1:0] word;
    logic              fault;
    logic              valid_q;
    logic              err_q;
    logic [DATA_W-1:0] data_q;

    assign run       = (state_q != ST_IDLE);
    assign clear     = (state_q == ST_IDLE) && start;
    assign smpl      = tick && ((state_q == ST_LEAD) || (state_q == ST_LOW));
    assign last_rise = cmp_q ? CW'(LAST_REP) : CW'(LAST_DATA);

    adc_rd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    adc_rd_capture #(.DATA_W(DATA_W), .CW(CW)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .smpl  (smpl),
        .idx   (rise_q + 1'b1),
        .din   (din),
        .word  (word),
        .fault (fault)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LEAD;
            ST_LEAD: if (tick)  state_d = ST_HIGH;
            ST_HIGH: if (tick)  state_d = (rise_q == last_rise) ? ST_FIN : ST_LOW;
            ST_LOW:  if (tick)  state_d = ST_HIGH;
            ST_FIN:  if (tick)  state_d = ST_IDLE;
            default:            state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rise_q  <= '0;
            cmp_q   <= 1'b0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            valid_q <= 1'b0;
            if (clear) begin
                rise_q <= '0;
                cmp_q  <= cmp_mode;
            end else if (smpl) begin
                rise_q <= rise_q + 1'b1;
            end
            if ((state_q == ST_FIN) && tick) begin
                valid_q <= 1'b1;
                data_q  <= word;
                err_q   <= fault;
            end
        end
    end

    always_comb begin
        cs_n     = (state_q == ST_IDLE) || (state_q == ST_FIN);
        dclk     = (state_q == ST_HIGH);
        busy     = (state_q != ST_IDLE);
        valid    = valid_q;
        error    = err_q;
        data_out = data_q;
    end

    // R3: serial clock only toggles high while the converter is selected
    a_r3_clk_needs_select: assert property (@(posedge clk) disable iff (rst)
        dclk |-> !cs_n);
    // R2: chip select falls only in answer to a start seen while idle
    a_r2_select_from_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(start) && !$past(busy));
    // R3: chip select never falls with the serial clock high
    a_r3_lead_low: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !dclk);
    // R8: result strobe only with chip select released and not busy
    a_r8_valid_released: assert property (@(posedge clk) disable iff (rst)
        valid |-> cs_n && !dclk && !busy);
    // R8: result strobe is a single cycle
    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    // R8: held result does not move between strobes
    a_r8_result_held: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(data_out) && $stable(error));
    // R6: sample count never passes the compare-mode limit
    a_r6_rise_bound: assert property (@(posedge clk) disable iff (rst)
        rise_q <= CW'(LAST_REP));
endmodule

// File: tb/adc_rdout_ctrl_bench.sv
module adc_rdout_ctrl_bench;
    localparam int DW = 12;
    localparam int DH = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          cmp_mode = 1'b0;
    logic          din = 1'b1;
    logic          busy;
    logic [DW-1:0] data_out;
    logic          valid;
    logic          error;
    logic          cs_n;
    logic          dclk;

    int vectors = 0;
    int fails = 0;

    logic [DW-1:0] dev_code = '0;
    logic          dev_null_hi = 1'b0;
    int            dev_flip = -1;
    int            fcnt = 0;
    int            rises = 0;
    int            cs_falls = 0;
    int            lead = 0;
    int            hi_len = 0;
    int            hi_min = 0;
    int            hi_max = 0;
    int            csh = 0;
    logic          prev_cs = 1'b1;
    logic          prev_dclk = 1'b0;

    always #10 clk = ~clk;

    adc_rdout_ctrl #(.DATA_W(DW), .HALF_DIV(DH)) u_adc_rdout_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmp_mode (cmp_mode),
        .busy     (busy),
        .data_out (data_out),
        .valid    (valid),
        .error    (error),
        .cs_n     (cs_n),
        .dclk     (dclk),
        .din      (din)
    );

    function automatic logic dev_bit(int f);
        if (f == 2) return dev_null_hi;
        if (f >= 3 && f <= DW + 2) return dev_code[DW + 2 - f];
        if (f >= DW + 3 && f <= 2 * DW + 1)
            return dev_code[f - DW - 2] ^ ((f - DW - 2) == dev_flip);
        return 1'b1;
    endfunction

    // converter model and edge monitor, all at the falling system edge
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_cs && !cs_n) begin
                cs_falls++;
                rises = 0; lead = 0; fcnt = 0;
                hi_len = 0; hi_min = 1000; hi_max = 0;
            end
            if (cs_n) begin
                csh++;
                din = 1'b1;
            end else begin
                csh = 0;
                if (prev_dclk && !dclk) begin
                    fcnt++;
                    din = dev_bit(fcnt);
                end
            end
            if (!prev_dclk && dclk) rises++;
            if (!cs_n && !dclk && rises == 0) lead++;
            if (dclk) hi_len++;
            if (prev_dclk && !dclk) begin
                if (hi_len < hi_min) hi_min = hi_len;
                if (hi_len > hi_max) hi_max = hi_len;
                hi_len = 0;
            end
            prev_dclk = dclk;
            prev_cs = cs_n;
        end
    end

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic conv(logic [DW-1:0] code, logic cmp, logic nhi, int flip);
        int n = 0;
        logic exp_err;
        dev_code = code; dev_null_hi = nhi; dev_flip = flip;
        cs_falls = 0;
        exp_err = nhi | (cmp && flip >= 1 && flip <= DW - 1);
        @(negedge clk); start = 1'b1; cmp_mode = cmp;
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1; cmp_mode = !cmp;      // R2 ignored start, R7 mode latched
        @(negedge clk); start = 1'b0;
        while (!valid && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R8 valid arrives", int'(valid), 1);
        chk("R5 data word", int'(data_out), int'(code));
        chk("R4/R7 error flag", int'(error), int'(exp_err));
        chk(cmp ? "R7 rise count" : "R6 rise count", rises, cmp ? 2 * DW + 2 : DW + 3);
        chk("R2 one select per start", cs_falls, 1);
        chk("R3 lead-in length", lead, DH);
        chk("R3 high min", hi_min, DH);
        chk("R3 high max", hi_max, DH);
        chk("R8 cs_n high at valid", int'(cs_n), 1);
        chk("R8 busy low at valid", int'(busy), 0);
        chk("R8 cs_n high time", int'(csh >= DH), 1);
        @(negedge clk);
        chk("R8 valid single cycle", int'(valid), 0);
        chk("R8 data held", int'(data_out), int'(code));
    endtask

    task automatic both(logic [DW-1:0] code);
        conv(code, 1'b0, 1'b0, -1);
        conv(code, 1'b1, 1'b0, -1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cs_n", int'(cs_n), 1);
        chk("R1 dclk", int'(dclk), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 valid", int'(valid), 0);
        chk("R1 error", int'(error), 0);

        // R5 code scale points
        both(12'h000);
        both(12'h800);
        both(12'h7FF);
        both(12'hFFF);
        for (int i = 0; i < DW; i++) begin
            both(DW'(1) << i);
            both(~(DW'(1) << i));
        end
        for (int c = 0; c < (1 << DW); c += 97) both(DW'(c));

        // R4 null bit high
        conv(12'hA5C, 1'b0, 1'b1, -1);
        conv(12'h3C3, 1'b1, 1'b1, -1);
        // R7 each repeat position flipped, R6 same flips unseen without compare
        for (int p = 0; p < DW; p++) begin
            conv(12'h6B2, 1'b1, 1'b0, p);
            conv(12'h6B2, 1'b0, 1'b0, p);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule